// File: doc/BRIEF.md
# Prescaled 8-bit Backlight PWM Generator

This block drives one pulse-width-modulated output, typically a display backlight. The counter advances either on every core clock cycle or only on cycles where a slower source pulses `slow_tick_i`. That count is divided by a power-of-two prescaler and fed to an 8-bit period counter. A compare value sets how many of the 256 counts in a period are active. A polarity bit decides whether the active part is driven high or low.

Software programs the block through a small register interface. One register holds the configuration word. One holds the source select. One accepts set-style run and stop commands. One reports whether the generator is really running. The run state passes through a two-stage synchronizer before it takes effect, and the status bit reports that synchronized state. A new configuration is held in a shadow copy and takes effect only at a period boundary, so a period is never cut short or stretched by a write.

Top module: `bl_pwm_gen`

## Requirements
- R1: Register address 0 holds the configuration word: compare value in bits 15:8, polarity in bit 4, prescaler select in bits 2:0. It reads back as written, and all other bits read 0.
- R2: A prescaler value of 7 is stored and read back as 6. Values 0 to 6 are stored unchanged.
- R3: While running, one PWM period lasts 256 × 2^prescaler source ticks.
- R4: The output is active for the first `compare` counts of each 256-count period. Compare 0 gives an output that is never active, and compare 255 gives 255 active counts out of 256.
- R5: With polarity 1 the active level is high. With polarity 0 the active level is low.
- R6: Register address 1 bit 0 selects the source. A value of 1 advances the prescaler on every clock. A value of 0 advances it only on cycles where `slow_tick_i` is 1. The select reads back.
- R7: A write to address 2 with bit 0 set starts the generator, and a write with bit 1 set stops it. When both bits are set, the stop wins. Status (address 3, bit 0) follows the command two clock edges after the write edge.
- R8: While not running, the output sits at the inactive level for the current polarity, and the counters are held at zero. Each new run starts at count 0.
- R9: A configuration written while running takes effect only at the next wrap of the counter from 255 to 0. While stopped, a configuration takes effect at once.
- R10: An asynchronous active-low reset clears the configuration, the source select, the run command and the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | One-cycle pulses from the slow timebase |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data (combinational) |
| pwm_o | output | 1 | PWM output |
| status_o | output | 1 | Generator running |

## Verification
The bench counts high cycles over a whole period at the extreme compare values 0 and 255 and at the largest prescaler. An off-by-one in the compare would show up at those points as one count too many or too few. A prescaler that does not saturate would let a written 7 double the period. The bench also writes both command bits at once, which catches a design where the start command wins. It checks status one and two edges after a command, which catches a synchronizer with the wrong depth. It rewrites the configuration in the middle of a period, and the reference model flags any design that applies the new compare value before the wrap.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int CMP_W   = 8;
  localparam int PS_W    = 3;
  localparam int PS_MAX  = 6;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 16;
  localparam int CMP_LSB = 8;
  localparam int POL_BIT = 4;
  localparam int SYNC_STAGES = 2;
  localparam int PRE_W   = (PS_MAX > 0) ? PS_MAX : 1;

  typedef struct packed {
    logic [CMP_W-1:0] cmp;
    logic             pol;
    logic [PS_W-1:0]  ps;
  } pwm_cfg_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG  = 2'd0,
    A_SRC  = 2'd1,
    A_CMD  = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              run_i,
  output pwm_cfg_t          cfg_o,
  output logic              sel_o,
  output logic              en_o
);
  pwm_cfg_t cfg_q;
  logic     sel_q, en_q;
  logic [PS_W-1:0] ps_wr;
  logic unused_bits;

  assign unused_bits = ^{wr_data_i[7:5], wr_data_i[3]};

  // saturate prescaler on entry
  assign ps_wr = (wr_data_i[PS_W-1:0] > PS_W'(PS_MAX)) ? PS_W'(PS_MAX)
                                                       : wr_data_i[PS_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      sel_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        A_CFG: begin
          cfg_q.cmp <= wr_data_i[CMP_LSB +: CMP_W];
          cfg_q.pol <= wr_data_i[POL_BIT];
          cfg_q.ps  <= ps_wr;
        end
        A_SRC: sel_q <= wr_data_i[0];
        A_CMD: begin
          if (wr_data_i[1])      en_q <= 1'b0;
          else if (wr_data_i[0]) en_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (reg_addr_e'(rd_addr_i))
      A_CFG: begin
        rd_data_o[CMP_LSB +: CMP_W] = cfg_q.cmp;
        rd_data_o[POL_BIT]          = cfg_q.pol;
        rd_data_o[PS_W-1:0]         = cfg_q.ps;
      end
      A_SRC:  rd_data_o[0] = sel_q;
      A_STAT: rd_data_o[0] = run_i;
      default: ;
    endcase
  end

  assign cfg_o = cfg_q;
  assign sel_o = sel_q;
  assign en_o  = en_q;

  assert_ps_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.ps <= PS_W'(PS_MAX));

  assert_stop_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_CMD && wr_data_i[1]) |=> !en_q);
endmodule

// File: rtl/bl_pwm_sync.sv
module bl_pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];

  assert_rise_lag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(d_i, STAGES));

  assert_fall_lag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(q_o) |-> !$past(d_i, STAGES));
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     src_tick_i,
  input  pwm_cfg_t cfg_i,
  output logic     pwm_o
);
  localparam logic [CMP_W-1:0] CNT_TOP = '1;

  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [CMP_W-1:0] cnt_q;
  pwm_cfg_t         sh_q;
  logic             pre_hit, at_top, active;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) pre_lim[i] = (i < int'(sh_q.ps));
  end

  assign pre_hit = src_tick_i && (pre_q == pre_lim);
  assign at_top  = (cnt_q == CNT_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      cnt_q <= '0;
      sh_q  <= cfg_i;
    end else if (src_tick_i) begin
      if (pre_hit) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
        if (at_top) sh_q <= cfg_i;  // new settings only at wrap
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign active = (cnt_q < sh_q.cmp);
  assign pwm_o  = run_i ? ~(active ^ sh_q.pol) : ~sh_q.pol;

  assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && pre_hit && at_top) |=> (cnt_q == '0));

  assert_prescale_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !pre_hit) |=> $stable(cnt_q));

  assert_zero_cmp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sh_q.cmp == '0) |-> (pwm_o == ~sh_q.pol));

  assert_idle_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0 && pre_q == '0));

  assert_shadow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !(pre_hit && at_top)) |=> $stable(sh_q));
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pwm_o,
  output logic              status_o
);
  pwm_cfg_t cfg;
  logic     sel, en, run, src_tick;

  bl_pwm_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .run_i     (run),
    .cfg_o     (cfg),
    .sel_o     (sel),
    .en_o      (en)
  );

  bl_pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (en),
    .q_o    (run)
  );

  assign src_tick = sel | slow_tick_i;

  bl_pwm_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .src_tick_i (src_tick),
    .cfg_i      (cfg),
    .pwm_o      (pwm_o)
  );

  assign status_o = run;

  assert_slow_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel && !slow_tick_i) |-> !src_tick);
endmodule

// File: tb/sim_bl_pwm_gen.sv
module sim_bl_pwm_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pwm, status;

  int checks = 0, fails = 0, cyc = 0, tphase = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  bl_pwm_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .pwm_o(pwm), .status_o(status)
  );

  // slow timebase: one pulse every third cycle
  always @(negedge clk) begin
    tphase = (tphase + 1) % 3;
    slow_tick <= (tphase == 0);
  end

  // behavioural reference
  int m_cmp, m_pol, m_ps, m_sel, m_en, m_s1, m_run, m_pre, m_cnt, s_cmp, s_pol, s_ps;
  int tick, run_old;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmp = 0; m_pol = 0; m_ps = 0; m_sel = 0; m_en = 0; m_s1 = 0; m_run = 0;
      m_pre = 0; m_cnt = 0; s_cmp = 0; s_pol = 0; s_ps = 0;
    end else begin
      tick = (m_sel != 0 || slow_tick) ? 1 : 0;
      run_old = m_run;
      m_run = m_s1;
      m_s1 = m_en;
      if (run_old == 0) begin
        m_pre = 0; m_cnt = 0; s_cmp = m_cmp; s_pol = m_pol; s_ps = m_ps;
      end else if (tick == 1) begin
        if (m_pre == (1 << s_ps) - 1) begin
          m_pre = 0;
          if (m_cnt == 255) begin
            m_cnt = 0; s_cmp = m_cmp; s_pol = m_pol; s_ps = m_ps;
          end else m_cnt = m_cnt + 1;
        end else m_pre = m_pre + 1;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            m_cmp = int'(wr_data[15:8]);
            m_pol = int'(wr_data[4]);
            m_ps  = (int'(wr_data[2:0]) > 6) ? 6 : int'(wr_data[2:0]);
          end
          2'd1: m_sel = int'(wr_data[0]);
          2'd2: if (wr_data[1]) m_en = 0; else if (wr_data[0]) m_en = 1;
          default: ;
        endcase
      end
    end
  end

  function automatic bit exp_pwm();
    bit act;
    act = (m_cnt < s_cmp);
    if (m_run == 0) return (s_pol == 0);
    return (s_pol != 0) ? act : !act;
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      checks++;
      if (pwm !== exp_pwm()) begin
        fails++;
        $display("FAIL R3 R4 R5 R8 R9 pwm_o actual %0b expected %0b at cycle %0d", pwm, exp_pwm(), cyc);
      end
      checks++;
      if (status !== (m_run != 0)) begin
        fails++;
        $display("FAIL R7 status_o actual %0b expected %0b at cycle %0d", status, m_run, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_rd(input logic [1:0] a, input logic [15:0] e, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s read addr %0d actual %h expected %h", req, a, rd_data, e);
    end
  endtask

  task automatic measure(input int n, input int e, input string req);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (pwm) highs++;
    end
    checks++;
    if (highs != e) begin
      fails++;
      $display("FAIL %s high count actual %0d expected %0d", req, highs, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check_rd(2'd0, 16'h0000, "R10");
    check_rd(2'd3, 16'h0000, "R10");
    checks++;
    if (pwm !== 1'b1) begin
      fails++;
      $display("FAIL R10 pwm_o in reset actual %0b expected 1", pwm);
    end
    @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    wr(2'd1, 16'h0001);
    check_rd(2'd1, 16'h0001, "R6");
    wr(2'd0, 16'h4010);
    check_rd(2'd0, 16'h4010, "R1");
    wr(2'd0, 16'hFFFF);
    check_rd(2'd0, 16'hFF16, "R1");
    wr(2'd0, 16'h4010);
    wr(2'd2, 16'h0001);
    check_rd(2'd3, 16'h0000, "R7");  // one edge after the write edge
    check_rd(2'd3, 16'h0001, "R7");  // two edges after
    repeat (300) @(negedge clk);
    measure(256, 64, "R4");

    wr(2'd0, 16'h0010);
    repeat (300) @(negedge clk);
    measure(256, 0, "R4");

    wr(2'd0, 16'hFF11);
    repeat (600) @(negedge clk);
    measure(512, 510, "R3 R4");

    wr(2'd0, 16'h8000);
    repeat (600) @(negedge clk);
    measure(256, 128, "R5");

    wr(2'd0, 16'h1017);
    check_rd(2'd0, 16'h1016, "R2");
    repeat (600) @(negedge clk);
    measure(16384, 1024, "R2 R3");

    // mid-period rewrites, checked against the model (R9)
    wr(2'd0, 16'h4010);
    repeat (16500) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      repeat (37 + 53 * k) @(negedge clk);
      wr(2'd0, 16'((k * 40 + 20) << 8) | 16'h0010);
    end
    repeat (600) @(negedge clk);

    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h4010);
    check_rd(2'd1, 16'h0000, "R6");
    repeat (1600) @(negedge clk);
    measure(768, 192, "R6");

    // both command bits: stop wins
    wr(2'd2, 16'h0003);
    repeat (3) @(negedge clk);
    check_rd(2'd3, 16'h0000, "R7");
    measure(100, 0, "R8");

    // restart from zero
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0001);
    repeat (2) @(negedge clk);
    measure(256, 64, "R8");

    repeat (5) @(negedge clk);
    cmp_on = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule